// File: doc/BRIEF.md
# Misaligned Read Splitting Adapter

This block sits between a load requester and a memory bus that can only move whole, naturally aligned 32-bit words. The requester asks for 1, 2 or 4 bytes starting at any byte address. The adapter decides how many aligned word reads the request needs. It issues one bus read when every requested byte lies in a single word. It issues two reads in back-to-back cycles when the bytes run past the end of a word. It then combines the fetched word or words into one result. That result is right-justified and little-endian, and its unused high bytes are zero.

A strict-mode input makes the adapter refuse requests that are not naturally aligned. In that mode it reports an error and touches no memory. The adapter handles one request at a time. Its request port uses a valid/ready handshake, and its response is a single-cycle pulse that carries the data and an error flag. The bus returns read data exactly one cycle after the adapter presents an address.

Top module: `unaligned_read_splitter`

## Requirements
- R1: Every bus read presents a byte address whose two low bits are zero. The first read of a request goes to the word that contains the request's starting byte (reqAddr with bits 1:0 cleared).
- R2: A request whose bytes all lie in one aligned word makes exactly one bus read. Example: a 2-byte read at 0x0005 makes one read at 0x0004.
- R3: A request that runs past a word boundary makes exactly two bus reads in consecutive cycles. The first read goes to the lower word and the second to the next word up (+4). Examples: a 2-byte read at offset 3, and a 4-byte read at any offset other than 0.
- R4: The result is little-endian and right-justified. The byte at reqAddr+i appears in rspData bits 8i+7:8i. Bytes that come from two words are merged into one result.
- R5: Result bytes beyond the requested size read as zero.
- R6: reqSize codes are: 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes. Code 3 is illegal. It returns rspErr=1 with zero data and makes no bus read.
- R7: When strictMode is 1 at acceptance, a request whose address is not a multiple of its size returns rspErr=1 with zero data and makes no bus read. When strictMode is 0, the same request completes with rspErr=0.
- R8: rspValid is a one-cycle pulse. Counting from the accepting clock edge, it appears 1 cycle later for a rejected request, 3 cycles later for a one-word request, and 4 cycles later for a split request.
- R9: reqReady is 1 when the adapter is idle. It is 0 from the cycle after acceptance through the response cycle.
- R10: A split request at the top of the address space takes its second word from address 0. The address wraps modulo 2^32.

Ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| strictMode | input | 1 | 1: reject misaligned requests; sampled at acceptance |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Adapter can accept a request |
| reqAddr | input | 32 | Byte address of the first requested byte |
| reqSize | input | 2 | Size code: 0=1 byte, 1=2 bytes, 2=4 bytes, 3=illegal |
| busReqValid | output | 1 | Bus read issued this cycle |
| busAddr | output | 32 | Word-aligned byte address of the bus read |
| busRdata | input | 32 | Read data, valid the cycle after busReqValid |
| rspValid | output | 1 | Response pulse |
| rspData | output | 32 | Right-justified, zero-filled result |
| rspErr | output | 1 | Request rejected |

## Verification
The bench targets the offsets where splitting starts: a 2-byte read at offset 3, and 4-byte reads at offsets 1, 2 and 3. A design that misjudged any of these would issue one read and return stale or wrong upper bytes. It would also respond a cycle early.

The 2-byte read at offset 1 checks the opposite mistake. A wrong design would split it anyway and show two bus reads and an extra cycle of latency.

A word read at 0xFFFFFFFE checks that the second word address wraps to 0. Byte reads at every offset check both the right shift and the zero fill.

The strict-mode cases and the illegal size code check the error path. A design that got these wrong would touch the bus, or would return non-zero data with the error.

// File: rtl/uas_pkg.sv
package uas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_LO,
    ST_GRAB_LO,
    ST_GRAB_HI,
    ST_RESP
  } uasState_t;

  // Strobes from control to datapath, one bit per action
  typedef struct packed {
    logic latchReq;   // capture the incoming request and its decode
    logic busIssue;   // drive a bus read this cycle
    logic busSelHi;   // bus read targets the upper word
    logic captureLo;  // store returned data as the lower word
    logic captureHi;  // store returned data as the upper word
    logic rspFire;    // response is presented this cycle
  } uasStrobe_t;

endpackage

// File: rtl/uas_control.sv
module uas_control
  import uas_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       inReject,
  input  logic       splitQ,
  output logic       reqReady,
  output uasStrobe_t strobe
);

  uasState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          stateNext       = inReject ? ST_RESP : ST_FETCH_LO;
        end
      end
      ST_FETCH_LO: begin
        strobe.busIssue = 1'b1;
        stateNext       = ST_GRAB_LO;
      end
      ST_GRAB_LO: begin
        strobe.captureLo = 1'b1;
        if (splitQ) begin
          strobe.busIssue = 1'b1;
          strobe.busSelHi = 1'b1;
          stateNext       = ST_GRAB_HI;
        end else begin
          stateNext = ST_RESP;
        end
      end
      ST_GRAB_HI: begin
        strobe.captureHi = 1'b1;
        stateNext        = ST_RESP;
      end
      ST_RESP: begin
        strobe.rspFire = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);

  // R9: acceptance closes the request port on the next cycle
  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R8: response lasts exactly one cycle
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rspFire |=> !strobe.rspFire);

  // R3: never more than two consecutive bus reads
  p_bus_burst_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busIssue && $past(strobe.busIssue)) |=> !strobe.busIssue);

endmodule

// File: rtl/uas_datapath.sv
module uas_datapath
  import uas_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  uasStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              strictMode,
  input  logic [DATA_W-1:0] busRdata,
  output logic              inReject,
  output logic              splitQ,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr
);

  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam int CNT_W = OFF_W + 2;

  // Decode of the incoming request
  logic [CNT_W-1:0] inOff, inBytes, inEnd;
  logic             inSizeBad, inSplit, inMis;

  always_comb begin
    inOff     = CNT_W'(reqAddr[OFF_W-1:0]);
    inBytes   = CNT_W'(1) << reqSize;
    inEnd     = inOff + inBytes;
    inSizeBad = (reqSize > SIZE_W'(OFF_W));
    inSplit   = (inEnd > CNT_W'(BYTES));
    inMis     = ((inOff & (inBytes - CNT_W'(1))) != '0);
    inReject  = inSizeBad | (strictMode & inMis);
  end

  // Held request state and fetched words
  logic [ADDR_W-1:0] addrQ;
  logic [SIZE_W-1:0] sizeQ;
  logic              errQ;
  logic [DATA_W-1:0] loWord, hiWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      sizeQ  <= '0;
      errQ   <= 1'b0;
      splitQ <= 1'b0;
      loWord <= '0;
      hiWord <= '0;
    end else begin
      if (strobe.latchReq) begin
        addrQ  <= reqAddr;
        sizeQ  <= reqSize;
        errQ   <= inReject;
        splitQ <= inSplit & ~inReject;
      end
      if (strobe.captureLo) loWord <= busRdata;
      if (strobe.captureHi) hiWord <= busRdata;
    end
  end

  // Bus addressing
  logic [ADDR_W-1:0] wordLo, wordHi;
  assign wordLo  = {addrQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign wordHi  = wordLo + ADDR_W'(BYTES);
  assign busAddr = strobe.busSelHi ? wordHi : wordLo;

  // Shift and merge
  logic [OFF_W-1:0]    offQ;
  logic [2*DATA_W-1:0] pair;
  logic [DATA_W-1:0]   aligned;
  logic [BYTES-1:0]    keep;

  assign offQ    = addrQ[OFF_W-1:0];
  assign pair    = {hiWord, loWord};
  assign aligned = DATA_W'(pair >> {offQ, 3'b000});

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign keep[i] = (sizeQ <= SIZE_W'(OFF_W)) && (i < (1 << sizeQ));
    assign rspData[i*8 +: 8] = (keep[i] && !errQ) ? aligned[i*8 +: 8] : 8'h00;
  end

  assign rspErr = errQ;

  // R1: bus reads are always word aligned
  p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.busIssue |-> (busAddr[OFF_W-1:0] == '0));

  // R3 / R10: second read targets the next word, wrapping at the top
  p_hi_follows_lo_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busIssue && strobe.busSelHi) |-> (busAddr == $past(busAddr) + ADDR_W'(BYTES)));

  // R7: rejected requests return zero data
  p_err_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rspFire && rspErr) |-> (rspData == '0));

  // R5: single-byte result has a zero upper part
  p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rspFire && sizeQ == '0) |-> (rspData[DATA_W-1:8] == '0));

endmodule

// File: rtl/unaligned_read_splitter.sv
module unaligned_read_splitter
  import uas_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strictMode,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  output logic              busReqValid,
  output logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busRdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr
);

  uasStrobe_t strobe;
  logic       inReject;
  logic       splitQ;

  uas_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .inReject (inReject),
    .splitQ   (splitQ),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  uas_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SIZE_W (SIZE_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .strictMode (strictMode),
    .busRdata   (busRdata),
    .inReject   (inReject),
    .splitQ     (splitQ),
    .busAddr    (busAddr),
    .rspData    (rspData),
    .rspErr     (rspErr)
  );

  assign busReqValid = strobe.busIssue;
  assign rspValid    = strobe.rspFire;

endmodule

// File: tb/unaligned_read_splitter_bench.sv
`timescale 1ns/1ps
module unaligned_read_splitter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strictMode = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        busReqValid;
  logic [31:0] busAddr;
  logic [31:0] busRdata = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        rspErr;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  unaligned_read_splitter u_unaligned_read_splitter (
    .clk(clk), .rstN(rstN), .strictMode(strictMode),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqSize(reqSize),
    .busReqValid(busReqValid), .busAddr(busAddr), .busRdata(busRdata),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h9E3779B1) ^ 32'h3C6EF372;
  endfunction

  function automatic logic [7:0] byteAt(input logic [31:0] a);
    logic [31:0] w;
    w = memWord(a);
    return w[a[1:0]*8 +: 8];
  endfunction

  function automatic logic [31:0] expData(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < (1 << sz); i++) r[i*8 +: 8] = byteAt(a + 32'(i));
    return r;
  endfunction

  // Memory model with one-cycle read latency
  always_ff @(posedge clk) begin
    if (busReqValid) busRdata <= memWord(busAddr);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doTxn(input logic [31:0] a, input logic [1:0] sz, input logic strict);
    int          lat;
    int          nBus;
    logic [31:0] seen0, seen1, gotData, eData;
    logic        gotErr, gotRsp, readyLeak, eRej, eSplit;
    int          eLat, eBus;
    lat = 0; nBus = 0; seen0 = '0; seen1 = '0; gotData = '0; gotErr = 1'b0;
    gotRsp = 1'b0; readyLeak = 1'b0;

    eRej   = (sz == 2'd3) || (strict && ((a & ((32'd1 << sz) - 32'd1)) != 0));
    eSplit = !eRej && ((32'(a[1:0]) + (32'd1 << sz)) > 32'd4);
    eLat   = eRej ? 1 : (eSplit ? 4 : 3);
    eBus   = eRej ? 0 : (eSplit ? 2 : 1);
    eData  = eRej ? 32'h0 : expData(a, sz);

    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSize = sz; strictMode = strict;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    forever begin
      if (busReqValid) begin
        if (nBus == 0) seen0 = busAddr;
        if (nBus == 1) seen1 = busAddr;
        nBus++;
      end
      if (reqReady) readyLeak = 1'b1;
      if (rspValid) begin
        gotRsp = 1'b1; gotData = rspData; gotErr = rspErr;
        break;
      end
      if (lat >= 12) break;
      @(negedge clk);
      lat++;
    end

    check(gotRsp && lat == eLat, "R8", "latency", 32'(lat), 32'(eLat));
    check(!readyLeak, "R9", "ready low while busy", 32'(readyLeak), 32'h0);
    check(gotErr == eRej, eRej ? "R7/R6" : "R7", "error flag", 32'(gotErr), 32'(eRej));
    check(gotData == eData, "R4/R5", "data", gotData, eData);
    check(nBus == eBus, eSplit ? "R3" : "R2", "bus read count", 32'(nBus), 32'(eBus));
    if (eBus >= 1)
      check(seen0 == {a[31:2], 2'b00}, "R1", "first bus address", seen0, {a[31:2], 2'b00});
    if (eBus == 2)
      check(seen1 == {a[31:2], 2'b00} + 32'd4, "R10", "second bus address", seen1,
            {a[31:2], 2'b00} + 32'd4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // Reset state
    check(reqReady == 1'b1, "R9", "reset ready", 32'(reqReady), 32'h1);
    check(busReqValid == 1'b0, "R2", "reset bus idle", 32'(busReqValid), 32'h0);
    check(rspValid == 1'b0, "R8", "reset no response", 32'(rspValid), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed corner cases
    doTxn(32'h0000_0005, 2'd1, 1'b0);    // R2: half inside word
    doTxn(32'h0000_0001, 2'd2, 1'b0);    // R3: word split at offset 1
    doTxn(32'h0000_0102, 2'd2, 1'b0);    // R3: word split at offset 2
    doTxn(32'h0000_0203, 2'd2, 1'b0);    // R3: word split at offset 3
    doTxn(32'h0000_0307, 2'd1, 1'b0);    // R3: half at offset 3
    doTxn(32'h0000_0400, 2'd2, 1'b0);    // R2: aligned word
    for (int o = 0; o < 4; o++) doTxn(32'h0000_0810 + 32'(o), 2'd0, 1'b0); // R5 bytes
    doTxn(32'hFFFF_FFFE, 2'd2, 1'b0);    // R10: wrap to zero
    doTxn(32'hFFFF_FFFF, 2'd1, 1'b0);    // R10: half wrap
    doTxn(32'h0000_0040, 2'd3, 1'b0);    // R6: illegal size
    doTxn(32'h0000_0041, 2'd1, 1'b1);    // R7: strict rejects odd half
    doTxn(32'h0000_0042, 2'd1, 1'b1);    // R7: strict accepts aligned half
    doTxn(32'h0000_0046, 2'd2, 1'b1);    // R7: strict rejects misaligned word
    doTxn(32'h0000_0048, 2'd2, 1'b1);    // R7: strict accepts aligned word
    doTxn(32'h0000_0043, 2'd0, 1'b1);    // R7: strict byte never rejected

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic [1:0]  sz;
      logic        st;
      a  = $urandom();
      if (($urandom() % 4) == 0) a = {16'hFFFF, a[15:0]};
      sz = 2'($urandom() % 4);
      st = (($urandom() % 3) == 0);
      doTxn(a, sz, st);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule